// File: doc/BRIEF.md
# Configuration Register Access Unit

This unit holds the three configuration registers of a pseudo-static RAM model: a bus setup register, a refresh setup register and a read-only identification word. It sits beside the array datapath. It sees each completed, already decoded bus operation as one cycle of `op_valid_i`, which carries the direction, the register-enable pin level, the address and the data word.

The registers can be reached in two ways. The first is the register-enable pin. With the pin high, two address bits pick the register, and a write takes its new value from the low address bits rather than the data bus. The second is an unlock sequence of ordinary array operations at the topmost address: two reads, then a write whose data names the register, then a fourth operation that moves the value in or out. During both kinds of access the unit raises `array_suppress_o` in the same cycle, so that the array path neither stores nor returns anything for that operation. Register read data comes back one cycle after the operation.

Top module: `cfgacc_unit`

## Requirements
- R1: After synchronous reset, the bus register reads 16'h9D1F, the refresh register reads 16'h0010 and `rd_valid_o` is low.
- R2: A pin-method write (`op_pin_i`=1, `op_write_i`=1) with address bits [19:18]=2'b10 loads the bus register, and with 2'b00 loads the refresh register. The value is address bits [15:0]. The data bus is ignored, and the new value shows on `bcr_o`/`rcr_o` after the next clock edge.
- R3: A pin-method read raises `rd_valid_o` for one cycle after the operation's clock edge. `rd_data_o` then holds the register picked by address bits [19:18] (10b bus, 00b refresh, 01b identification). All other address bits are ignored.
- R4: The identification word is row-length flag [15], version [14:11], density [10:8], generation [7:5], with [4:0] zero (16'h9340 by default). Writes to it by either method leave it unchanged.
- R5: The sequence read, read, write, write, with every operation at address 22'h3FFFFF and the pin low, loads the register named by the third write's data (0000h refresh, 0001h bus, 0002h identification) with the fourth write's data.
- R6: The same sequence with a read as the fourth operation returns the named register on `rd_data_o` with `rd_valid_o` high, one cycle later.
- R7: `array_suppress_o` is high during every pin-method operation, during a sequence's third write when it names a valid register, and during its fourth operation. It is low during the sequence's two opening reads.
- R8: An operation at any other address, a pin-method operation, or an operation in the wrong direction returns the detector to its start. A following write at the top address then reaches the array, and no register changes.
- R9: If the third write's data is not 0000h, 0001h or 0002h, the sequence is abandoned. That write and the next one are not suppressed, and no register changes.
- R10: A pin-method access with address bits [19:18]=2'b11 changes no register, and a read of it returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | One completed bus operation this cycle |
| op_write_i | input | 1 | 1 = write, 0 = read |
| op_pin_i | input | 1 | Register-enable pin level for the operation |
| op_addr_i | input | 22 | Operation address |
| op_data_i | input | 16 | Write data of the operation |
| array_suppress_o | output | 1 | Array must ignore this operation |
| rd_valid_o | output | 1 | Register read data valid |
| rd_data_o | output | 16 | Register read data |
| bcr_o | output | 16 | Current bus setup register |
| rcr_o | output | 16 | Current refresh setup register |

## Verification
Pin-method accesses are driven with junk in the ignored address bits and a data bus that differs from the address value. This separates a correct field select from a full-address decode, and a value taken from the address from one taken from the data. Unlock sequences are applied whole for each register and each direction. They are also applied broken at each step: by a foreign address, by a pin operation inserted between steps, by an opening write, and by an unknown selector. These cases separate a detector that resets from one that resumes or skips steps. Every operation's suppress level is compared with the expected value, so a block that hides too many or too few array operations is reported.

// File: rtl/cfgacc_pkg.sv
package cfgacc_pkg;

    localparam int ADDR_W = 22;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        TGT_RCR  = 2'd0,
        TGT_BCR  = 2'd1,
        TGT_DIDR = 2'd2,
        TGT_NONE = 2'd3
    } cfg_target_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ1 = 2'd1,
        SQ_READ2 = 2'd2,
        SQ_ARMED = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              pin;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    typedef struct packed {
        logic              en;
        logic              write;
        cfg_target_e       tgt;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    // Register chosen by the two select address bits in the pin method
    function automatic cfg_target_e pin_target(input logic [1:0] sel);
        case (sel)
            2'b10:   return TGT_BCR;
            2'b00:   return TGT_RCR;
            2'b01:   return TGT_DIDR;
            default: return TGT_NONE;
        endcase
    endfunction

    // Register named by the selector word of the unlock sequence
    function automatic cfg_target_e seq_target(input logic [DATA_W-1:0] code);
        case (code)
            16'h0000: return TGT_RCR;
            16'h0001: return TGT_BCR;
            16'h0002: return TGT_DIDR;
            default:  return TGT_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] build_id(input logic       row_flag,
                                                   input logic [3:0] version,
                                                   input logic [2:0] density,
                                                   input logic [2:0] generation);
        return {row_flag, version, density, generation, 5'b00000};
    endfunction

endpackage

// File: rtl/cfgacc_seq_detect.sv
module cfgacc_seq_detect
    import cfgacc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}}
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_op_t  op_i,
    output reg_req_t sw_req_o,
    output logic     seq_supp_o
);

    seq_state_e  state_q, state_d;
    cfg_target_e tgt_q, tgt_d;
    cfg_target_e code_tgt;
    logic        at_top;
    logic        code_ok;

    assign at_top   = op_i.valid && !op_i.pin && (op_i.addr == TOP_ADDR);
    assign code_tgt = seq_target(op_i.data);
    assign code_ok  = (code_tgt != TGT_NONE);

    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        if (op_i.valid) begin
            if (!at_top) begin
                state_d = SQ_IDLE;
            end else begin
                case (state_q)
                    SQ_IDLE:  state_d = op_i.write ? SQ_IDLE : SQ_READ1;
                    SQ_READ1: state_d = op_i.write ? SQ_IDLE : SQ_READ2;
                    SQ_READ2: begin
                        if (op_i.write && code_ok) begin
                            state_d = SQ_ARMED;
                            tgt_d   = code_tgt;
                        end else begin
                            state_d = SQ_IDLE;
                        end
                    end
                    default:  state_d = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            tgt_q   <= TGT_NONE;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    always_comb begin
        sw_req_o.en    = at_top && (state_q == SQ_ARMED);
        sw_req_o.write = op_i.write;
        sw_req_o.tgt   = tgt_q;
        sw_req_o.wdata = op_i.data;
    end

    assign seq_supp_o = at_top &&
                        (((state_q == SQ_READ2) && op_i.write && code_ok) ||
                         (state_q == SQ_ARMED));

    // R8: a foreign or pin-method operation always restarts the detector
    assert_seq_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i.valid && !at_top) |=> (state_q == SQ_IDLE));

    // R5: the armed state is only reached through a write
    assert_armed_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == SQ_ARMED) |-> $past(op_i.valid && op_i.write));

endmodule

// File: rtl/cfgacc_regs.sv
module cfgacc_regs
    import cfgacc_pkg::*;
#(
    parameter logic [DATA_W-1:0] BCR_RST = 16'h9D1F,
    parameter logic [DATA_W-1:0] RCR_RST = 16'h0010,
    parameter logic [DATA_W-1:0] ID_VAL  = 16'h9340
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] bcr_o,
    output logic [DATA_W-1:0] rcr_o
);

    logic [DATA_W-1:0] bcr_q, rcr_q, rd_q, rd_mux;
    logic              rdv_q;
    logic              wr_bcr, wr_rcr, rd_en;

    assign wr_bcr = req_i.en && req_i.write && (req_i.tgt == TGT_BCR);
    assign wr_rcr = req_i.en && req_i.write && (req_i.tgt == TGT_RCR);
    assign rd_en  = req_i.en && !req_i.write;

    always_comb begin
        case (req_i.tgt)
            TGT_BCR:  rd_mux = bcr_q;
            TGT_RCR:  rd_mux = rcr_q;
            TGT_DIDR: rd_mux = ID_VAL;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bcr_q <= BCR_RST;
            rcr_q <= RCR_RST;
            rdv_q <= 1'b0;
            rd_q  <= '0;
        end else begin
            if (wr_bcr) bcr_q <= req_i.wdata;
            if (wr_rcr) rcr_q <= req_i.wdata;
            rdv_q <= rd_en;
            rd_q  <= rd_en ? rd_mux : '0;
        end
    end

    assign rd_valid_o = rdv_q;
    assign rd_data_o  = rd_q;
    assign bcr_o      = bcr_q;
    assign rcr_o      = rcr_q;

    // R2: the bus register only moves on a write aimed at it
    assert_bcr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(req_i.en && req_i.write && req_i.tgt == TGT_BCR) |=> $stable(bcr_o));

    // R4: identification reads always return the fixed word
    assert_id_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (req_i.en && !req_i.write && req_i.tgt == TGT_DIDR) |=> (rd_data_o == ID_VAL));

endmodule

// File: rtl/cfgacc_unit.sv
module cfgacc_unit
    import cfgacc_pkg::*;
#(
    parameter int                SEL_LSB    = 18,
    parameter logic [DATA_W-1:0] BCR_RST    = 16'h9D1F,
    parameter logic [DATA_W-1:0] RCR_RST    = 16'h0010,
    parameter logic              ID_ROW     = 1'b1,
    parameter logic [3:0]        ID_VERSION = 4'h2,
    parameter logic [2:0]        ID_DENSITY = 3'd3,
    parameter logic [2:0]        ID_GEN     = 3'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid_i,
    input  logic              op_write_i,
    input  logic              op_pin_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [DATA_W-1:0] op_data_i,
    output logic              array_suppress_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] bcr_o,
    output logic [DATA_W-1:0] rcr_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [DATA_W-1:0] ID_VAL   = build_id(ID_ROW, ID_VERSION, ID_DENSITY, ID_GEN);

    bus_op_t  op;
    reg_req_t pin_req, sw_req, req;
    logic     seq_supp;

    always_comb begin
        op.valid = op_valid_i;
        op.write = op_write_i;
        op.pin   = op_pin_i;
        op.addr  = op_addr_i;
        op.data  = op_data_i;
    end

    always_comb begin
        pin_req.en    = op_valid_i && op_pin_i;
        pin_req.write = op_write_i;
        pin_req.tgt   = pin_target(op_addr_i[SEL_LSB+1:SEL_LSB]);
        pin_req.wdata = op_addr_i[DATA_W-1:0];
    end

    assign req = op_pin_i ? pin_req : sw_req;

    cfgacc_seq_detect #(.TOP_ADDR(TOP_ADDR)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op),
        .sw_req_o   (sw_req),
        .seq_supp_o (seq_supp)
    );

    cfgacc_regs #(.BCR_RST(BCR_RST), .RCR_RST(RCR_RST), .ID_VAL(ID_VAL)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .bcr_o      (bcr_o),
        .rcr_o      (rcr_o)
    );

    assign array_suppress_o = (op_valid_i && op_pin_i) || seq_supp;

    // R7: every pin-method operation is hidden from the array
    assert_pin_suppress_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && op_pin_i) |-> array_suppress_o);

    // R3: a pin-method read returns data on the following cycle
    assert_pin_read_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && op_pin_i && !op_write_i) |=> rd_valid_o);

    // R6: read data appears only after a read operation
    assert_rd_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(op_valid_i && !op_write_i));

endmodule

// File: tb/tb_cfgacc_unit.sv
module tb_cfgacc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid_i, op_write_i, op_pin_i;
    logic [21:0] op_addr_i;
    logic [15:0] op_data_i;
    logic        array_suppress_o, rd_valid_o;
    logic [15:0] rd_data_o, bcr_o, rcr_o;

    int checks = 0;
    int fails  = 0;

    localparam logic [21:0] TOP = 22'h3FFFFF;
    localparam logic [15:0] ID  = 16'h9340;

    always #4 clk = ~clk;

    cfgacc_unit dut (
        .clk(clk), .rst(rst),
        .op_valid_i(op_valid_i), .op_write_i(op_write_i), .op_pin_i(op_pin_i),
        .op_addr_i(op_addr_i), .op_data_i(op_data_i),
        .array_suppress_o(array_suppress_o), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o), .bcr_o(bcr_o), .rcr_o(rcr_o)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One operation: suppress is sampled during it, read results one cycle later
    task automatic op(input logic w, input logic p, input logic [21:0] a, input logic [15:0] d,
                      output logic supp, output logic rv, output logic [15:0] rd);
        @(negedge clk);
        op_valid_i = 1'b1; op_write_i = w; op_pin_i = p; op_addr_i = a; op_data_i = d;
        #1 supp = array_suppress_o;
        @(negedge clk);
        op_valid_i = 1'b0; op_write_i = 1'b0; op_pin_i = 1'b0;
        rv = rd_valid_o; rd = rd_data_o;
    endtask

    task automatic t_reset();
        check(bcr_o == 16'h9D1F, "R1 bus reset", bcr_o, 16'h9D1F);
        check(rcr_o == 16'h0010, "R1 refresh reset", rcr_o, 16'h0010);
        check(rd_valid_o == 1'b0, "R1 rd_valid reset", {15'd0, rd_valid_o}, 16'd0);
    endtask

    task automatic t_pin_write();
        logic s, v; logic [15:0] r;
        op(1, 1, {2'b00, 2'b10, 2'b00, 16'h1234}, 16'hFFFF, s, v, r);
        check(s, "R7 pin write suppress", {15'd0, s}, 16'd1);
        check(bcr_o == 16'h1234, "R2 bus from address", bcr_o, 16'h1234);
        op(1, 1, {2'b11, 2'b00, 2'b01, 16'h0081}, 16'h5555, s, v, r);
        check(rcr_o == 16'h0081, "R2 refresh from address", rcr_o, 16'h0081);
        check(bcr_o == 16'h1234, "R2 bus untouched", bcr_o, 16'h1234);
    endtask

    task automatic t_pin_read();
        logic s, v; logic [15:0] r;
        op(0, 1, {2'b11, 2'b10, 2'b11, 16'hBEEF}, 16'h0, s, v, r);
        check(v && r == 16'h1234, "R3 pin read bus", r, 16'h1234);
        op(0, 1, {2'b01, 2'b00, 2'b10, 16'h0F0F}, 16'h0, s, v, r);
        check(v && r == 16'h0081, "R3 pin read refresh", r, 16'h0081);
        op(0, 1, {2'b10, 2'b01, 2'b00, 16'h7777}, 16'h0, s, v, r);
        check(v && r == ID, "R4 pin read id", r, ID);
        check(s, "R7 pin read suppress", {15'd0, s}, 16'd1);
    endtask

    task automatic t_id_write_pin();
        logic s, v; logic [15:0] r;
        op(1, 1, {2'b00, 2'b01, 2'b00, 16'h0000}, 16'h0, s, v, r);
        op(0, 1, {2'b00, 2'b01, 2'b00, 16'h0000}, 16'h0, s, v, r);
        check(r == ID, "R4 id ignores pin write", r, ID);
        check(bcr_o == 16'h1234 && rcr_o == 16'h0081, "R4 others untouched", bcr_o, 16'h1234);
    endtask

    task automatic t_unused_select();
        logic s, v; logic [15:0] r;
        op(1, 1, {2'b00, 2'b11, 2'b00, 16'hAAAA}, 16'h0, s, v, r);
        check(bcr_o == 16'h1234 && rcr_o == 16'h0081, "R10 write to 11b ignored", bcr_o, 16'h1234);
        op(0, 1, {2'b00, 2'b11, 2'b00, 16'h0000}, 16'h0, s, v, r);
        check(v && r == 16'h0000, "R10 read of 11b", r, 16'h0000);
    endtask

    task automatic t_sw_write_bus();
        logic s1, s2, s3, s4, v; logic [15:0] r;
        op(0, 0, TOP, 16'h0, s1, v, r);
        check(!v, "R6 opening read not a register read", {15'd0, v}, 16'd0);
        op(0, 0, TOP, 16'h0, s2, v, r);
        op(1, 0, TOP, 16'h0001, s3, v, r);
        op(1, 0, TOP, 16'hABCD, s4, v, r);
        check({s1, s2, s3, s4} == 4'b0011, "R7 sequence suppress pattern", {12'd0, s1, s2, s3, s4}, 16'h0003);
        check(bcr_o == 16'hABCD, "R5 sequence writes bus", bcr_o, 16'hABCD);
    endtask

    task automatic t_sw_read_refresh();
        logic s, v; logic [15:0] r;
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0000, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        check(v && r == 16'h0081, "R6 sequence reads refresh", r, 16'h0081);
        check(s, "R7 fourth read suppressed", {15'd0, s}, 16'd1);
    endtask

    task automatic t_sw_id();
        logic s, v; logic [15:0] r;
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0002, s, v, r);
        op(1, 0, TOP, 16'h0000, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0002, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        check(v && r == ID, "R4 id ignores sequence write", r, ID);
        check(rcr_o == 16'h0081 && bcr_o == 16'hABCD, "R5 id select leaves others", rcr_o, 16'h0081);
    endtask

    task automatic t_abort();
        logic s, s2, v; logic [15:0] r;
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 0, 22'h000100, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0001, s, v, r);
        op(1, 0, TOP, 16'h1111, s2, v, r);
        check(!s && !s2, "R8 foreign address restarts", {14'd0, s, s2}, 16'd0);
        check(bcr_o == 16'hABCD, "R8 bus unchanged after abort", bcr_o, 16'hABCD);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 1, {2'b00, 2'b00, 18'h0}, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0001, s, v, r);
        check(!s, "R8 pin operation restarts", {15'd0, s}, 16'd0);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0001, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0001, s, v, r);
        op(1, 0, TOP, 16'h2222, s2, v, r);
        check(!s && !s2 && bcr_o == 16'hABCD, "R8 early write restarts", bcr_o, 16'hABCD);
    endtask

    task automatic t_bad_code();
        logic s, s2, v; logic [15:0] r;
        op(0, 0, TOP, 16'h0, s, v, r);
        op(0, 0, TOP, 16'h0, s, v, r);
        op(1, 0, TOP, 16'h0005, s, v, r);
        op(1, 0, TOP, 16'h3333, s2, v, r);
        check(!s && !s2, "R9 unknown selector not suppressed", {14'd0, s, s2}, 16'd0);
        check(bcr_o == 16'hABCD && rcr_o == 16'h0081, "R9 registers unchanged", rcr_o, 16'h0081);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        op_valid_i = 1'b0; op_write_i = 1'b0; op_pin_i = 1'b0;
        op_addr_i = '0; op_data_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pin_write();
        t_pin_read();
        t_id_write_pin();
        t_unused_select();
        t_sw_write_bus();
        t_sw_read_refresh();
        t_sw_id();
        t_abort();
        t_bad_code();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule